// File: doc/BRIEF.md
# Node Reset and Clock-Stable Supervisor

This block produces the internal reset of a node controller. It merges four conditions into one active-high core reset: a power-on input from the analog supply monitor, an active-low external reset pin, a digital low-supply indication from a voltage comparator, and a clock-good flag from an oscillator monitor. The core stays in reset until the supply is good, the clock is good and the pin is released. After power-up, or after any low-supply trip, release is further delayed by a programmable number of stable clock cycles. This gives an external oscillator time to settle, which can take several milliseconds.

The external pin, the supply flag, the clock flag and the test input are brought into the clock domain through two-flop synchronisers. The pin also passes a debounce filter. Power-on reset asserts the core reset asynchronously. Every other source asserts it on the next clock edge. Release always passes through a two-stage chain. A test-mode input is captured each time the core enters reset. When it is captured high, the permits for the I/O, address and data bus output enables are withdrawn, so those buses go to high impedance. The captured value holds until the next reset entry. A cause code reports which condition triggered the most recent reset.

Top module: `rsv_reset_supervisor`

## Requirements
- R1: While `por_i` is high, `core_rst` is 1 at once, with no clock edge needed, and `rst_cause` is 1 (power-up).
- R2: After power-up or a low-supply trip, `core_rst` stays 1 until `STAB_CYCLES` clock cycles have passed with the clock good and the supply good. Release then follows within a few cycles.
- R3: When `low_supply` is high, `core_rst` is 1 within 3 cycles and stays 1 while the input stays high. The resulting reset records `rst_cause` 2.
- R4: `ext_rst_n` is active low and debounced. A low pulse shorter than `DEB_CYCLES` cycles has no effect on `core_rst` or `rst_cause`. A low level held longer asserts `core_rst` and records `rst_cause` 3. Release follows the pin rising, with no stabilisation wait.
- R5: When `clk_ok` is low, `core_rst` is held at 1 and `rst_cause` is 0. When it returns high, the core is released without a new stabilisation wait.
- R6: `core_rst` falls only after the release condition has held for two consecutive clock edges.
- R7: `test_mode` is sampled at each reset entry, including power-up. If the sample is 1, all three bus enable permits are 0. If it is 0, they are 1. The permits hold their value until the next entry and ignore `test_mode` changes in between.
- R8: When several causes start together, the recorded cause follows a fixed priority: low supply (2) first, then pin (3), then clock loss (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_i | input | 1 | Power-on reset from the supply monitor, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low |
| low_supply | input | 1 | High when the supply is below the trip point |
| clk_ok | input | 1 | High when the oscillator is stable |
| test_mode | input | 1 | Test input, sampled at reset entry |
| core_rst | output | 1 | Internal core reset, active high |
| io_oe_allow | output | 1 | Permit for the I/O bus output enables |
| addr_oe_allow | output | 1 | Permit for the address bus output enables |
| data_oe_allow | output | 1 | Permit for the data bus output enables |
| rst_cause | output | 2 | Last cause: 0 clock loss, 1 power-up, 2 low supply, 3 pin |

## Verification
- **Stuck or stale stabilisation state:** the core reset would be released too early or never. This shows on `core_rst` within one stabilisation interval of a power-up or supply trip.
- **Bad debounce count:** a short pin glitch would reach `core_rst`, or a held press would be missed. Either shows a few cycles after `DEB_CYCLES`.
- **Wrong latched test value:** all three bus permits are wrong from the first cycle after reset entry. The fault stays visible until the next entry.
- **Wrong cause priority:** `rst_cause` reads wrong on the cycle after entry.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    // Reset cause codes, visible on the rst_cause port
    typedef enum logic [1:0] {
        CAUSE_CLOCK  = 2'd0,
        CAUSE_POWER  = 2'd1,
        CAUSE_SUPPLY = 2'd2,
        CAUSE_PIN    = 2'd3
    } cause_e;

    // Synchronised view of the raw condition inputs
    typedef struct packed {
        logic pin_low;
        logic supply_low;
        logic clk_good;
        logic test;
    } cond_t;

    // Safe values held in the synchronisers during power-on reset
    localparam cond_t COND_SAFE = '{pin_low: 1'b0, supply_low: 1'b1,
                                    clk_good: 1'b0, test: 1'b0};

    // Priority among simultaneous causes: supply, then pin, then clock
    function automatic cause_e pick_cause(input cond_t c, input logic pin_req);
        if (c.supply_low)  return CAUSE_SUPPLY;
        else if (pin_req)  return CAUSE_PIN;
        else               return CAUSE_CLOCK;
    endfunction

endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         por_i,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q, stage2_q;

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/rsv_debounce.sv
module rsv_debounce #(
    parameter int DEB_CYCLES = 8
) (
    input  logic clk,
    input  logic por_i,
    input  logic level_i,
    output logic level_o
);
    localparam int CW = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          out_q;

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else if (level_i == out_q) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            out_q <= level_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign level_o = out_q;

    // R4: the filtered level only moves after a full run of differing samples
    p_filter_run_r4: assert property (@(posedge clk) disable iff (por_i)
        (out_q != $past(out_q)) |-> ($past(cnt_q) == LAST))
        else $error("debounce output moved early");
endmodule

// File: rtl/rsv_stab_timer.sv
module rsv_stab_timer #(
    parameter int STAB_CYCLES = 1250000
) (
    input  logic clk,
    input  logic por_i,
    input  logic restart_i,
    input  logic run_i,
    output logic done_o
);
    localparam int SW = $clog2(STAB_CYCLES + 1);
    localparam logic [SW-1:0] LAST = SW'(STAB_CYCLES - 1);

    logic [SW-1:0] cnt_q;
    logic          done_q;

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (restart_i) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (run_i && !done_q) begin
            if (cnt_q == LAST) done_q <= 1'b1;
            else               cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign done_o = done_q;

    // R2: completion only after the full count
    p_done_after_count_r2: assert property (@(posedge clk) disable iff (por_i)
        $rose(done_q) |-> ($past(cnt_q) == LAST))
        else $error("stabilisation finished early");

    // R2: a restart always clears completion
    p_restart_clears_r2: assert property (@(posedge clk) disable iff (por_i)
        restart_i |=> !done_q)
        else $error("restart did not clear");
endmodule

// File: rtl/rsv_reset_supervisor.sv
module rsv_reset_supervisor
    import rsv_pkg::*;
#(
    parameter int STAB_CYCLES = 1250000,
    parameter int DEB_CYCLES  = 8
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic       ext_rst_n,
    input  logic       low_supply,
    input  logic       clk_ok,
    input  logic       test_mode,
    output logic       core_rst,
    output logic       io_oe_allow,
    output logic       addr_oe_allow,
    output logic       data_oe_allow,
    output logic [1:0] rst_cause
);
    localparam int CONDW = $bits(cond_t);

    cond_t raw_cond, cond_s;
    logic  pin_req, stab_done, release_ok;
    logic  ok_q, hiz_q, entry_run, entry_pwr;
    logic  [1:0] rel_chain_q;
    logic  [2:0] arm_q;
    cause_e cause_q;

    assign raw_cond = '{pin_low: ~ext_rst_n, supply_low: low_supply,
                        clk_good: clk_ok, test: test_mode};

    rsv_sync #(.W(CONDW), .RST_VAL(COND_SAFE)) u_sync (
        .clk(clk), .por_i(por_i), .d(raw_cond), .q(cond_s));

    rsv_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
        .clk(clk), .por_i(por_i), .level_i(cond_s.pin_low), .level_o(pin_req));

    rsv_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
        .clk(clk), .por_i(por_i), .restart_i(cond_s.supply_low),
        .run_i(cond_s.clk_good), .done_o(stab_done));

    assign release_ok = stab_done & cond_s.clk_good & ~cond_s.supply_low & ~pin_req;

    // Two-stage release chain, set asynchronously by power-on
    always_ff @(posedge clk or posedge por_i) begin
        if (por_i)           rel_chain_q <= 2'b11;
        else if (!release_ok) rel_chain_q <= 2'b11;
        else                 rel_chain_q <= {rel_chain_q[0], 1'b0};
    end
    assign core_rst = rel_chain_q[1];

    // Entry detection: release condition lost, or synchroniser filled after power-on
    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            ok_q  <= 1'b0;
            arm_q <= 3'b111;
        end else begin
            ok_q  <= release_ok;
            arm_q <= {arm_q[1:0], 1'b0};
        end
    end
    assign entry_run = ok_q & ~release_ok;
    assign entry_pwr = arm_q[2] & ~arm_q[1];

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            hiz_q   <= 1'b0;
            cause_q <= CAUSE_POWER;
        end else begin
            if (entry_run || entry_pwr) hiz_q <= cond_s.test;
            if (entry_run) cause_q <= pick_cause(cond_s, pin_req);
        end
    end

    assign io_oe_allow   = ~hiz_q;
    assign addr_oe_allow = ~hiz_q;
    assign data_oe_allow = ~hiz_q;
    assign rst_cause     = cause_q;

    // R3: a synchronised supply trip holds the core in reset next cycle
    p_supply_holds_r3: assert property (@(posedge clk) disable iff (por_i)
        cond_s.supply_low |=> core_rst)
        else $error("core left running under low supply");

    // R4: an accepted pin request holds the core in reset
    p_pin_holds_r4: assert property (@(posedge clk) disable iff (por_i)
        pin_req |=> core_rst)
        else $error("core left running during pin reset");

    // R6: release needs two edges of a good condition
    p_two_stage_release_r6: assert property (@(posedge clk) disable iff (por_i)
        $fell(core_rst) |-> ($past(release_ok) && $past(release_ok, 2)))
        else $error("release skipped a stage");

    // R7: the bus permit changes only at reset entry
    p_hiz_latched_r7: assert property (@(posedge clk) disable iff (por_i)
        !(entry_run || entry_pwr) |=> $stable(hiz_q))
        else $error("bus permit moved outside entry");

    // R8: a supply trip present at entry wins the cause code
    p_supply_priority_r8: assert property (@(posedge clk) disable iff (por_i)
        (entry_run && cond_s.supply_low) |=> (cause_q == CAUSE_SUPPLY))
        else $error("cause priority wrong");
endmodule

// File: tb/tb_rsv_reset_supervisor.sv
`timescale 1ns/1ps
module tb_rsv_reset_supervisor;
    localparam int STAB = 200;
    localparam int DEB  = 8;

    logic clk = 1'b0;
    logic por_i = 1'b1, ext_rst_n = 1'b1, low_supply = 1'b0, clk_ok = 1'b1, test_mode = 1'b0;
    logic core_rst, io_oe_allow, addr_oe_allow, data_oe_allow;
    logic [1:0] rst_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rsv_reset_supervisor #(.STAB_CYCLES(STAB), .DEB_CYCLES(DEB)) dut (
        .clk(clk), .por_i(por_i), .ext_rst_n(ext_rst_n), .low_supply(low_supply),
        .clk_ok(clk_ok), .test_mode(test_mode), .core_rst(core_rst),
        .io_oe_allow(io_oe_allow), .addr_oe_allow(addr_oe_allow),
        .data_oe_allow(data_oe_allow), .rst_cause(rst_cause));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int oe3();
        return {io_oe_allow, addr_oe_allow, data_oe_allow};
    endfunction

    // R1 + R2: power-on reset state and stabilisation release
    task automatic t_power_up();
        cyc(1);
        chk(core_rst == 1'b1, "R1 reset held", core_rst, 1);
        chk(rst_cause == 2'd1, "R1 cause power", rst_cause, 1);
        chk(oe3() == 7, "R7 permits after por", oe3(), 7);
        por_i = 1'b0;
        cyc(STAB - 4);
        chk(core_rst == 1'b1, "R2 held before count", core_rst, 1);
        cyc(14);
        chk(core_rst == 1'b0, "R2 released", core_rst, 0);
        chk(oe3() == 7, "R7 permits test low", oe3(), 7);
    endtask

    // R1: asynchronous assertion mid-run
    task automatic t_async_por();
        #1 por_i = 1'b1;
        #0.5;
        chk(core_rst == 1'b1, "R1 async assert", core_rst, 1);
        chk(rst_cause == 2'd1, "R1 cause power again", rst_cause, 1);
        cyc(2);
        por_i = 1'b0;
        cyc(STAB + 12);
        chk(core_rst == 1'b0, "R2 released after por", core_rst, 0);
    endtask

    // R4: short glitch ignored
    task automatic t_pin_glitch();
        int c0;
        c0 = rst_cause;
        ext_rst_n = 1'b0;
        cyc(DEB - 3);
        ext_rst_n = 1'b1;
        cyc(20);
        chk(core_rst == 1'b0, "R4 glitch ignored", core_rst, 0);
        chk(rst_cause == c0, "R4 cause unchanged", rst_cause, c0);
    endtask

    // R4: held press resets, release has no stabilisation wait
    task automatic t_pin_hold();
        ext_rst_n = 1'b0;
        cyc(DEB + 6);
        chk(core_rst == 1'b1, "R4 pin asserts", core_rst, 1);
        chk(rst_cause == 2'd3, "R4 cause pin", rst_cause, 3);
        ext_rst_n = 1'b1;
        cyc(DEB + 8);
        chk(core_rst == 1'b0, "R4 quick release", core_rst, 0);
    endtask

    // R3 + R2: low supply holds and restarts stabilisation
    task automatic t_low_supply();
        low_supply = 1'b1;
        cyc(4);
        chk(core_rst == 1'b1, "R3 supply asserts", core_rst, 1);
        chk(rst_cause == 2'd2, "R3 cause supply", rst_cause, 2);
        cyc(30);
        chk(core_rst == 1'b1, "R3 held while low", core_rst, 1);
        low_supply = 1'b0;
        cyc(STAB - 4);
        chk(core_rst == 1'b1, "R2 restart wait", core_rst, 1);
        cyc(14);
        chk(core_rst == 1'b0, "R2 released after supply", core_rst, 0);
    endtask

    // R5: clock loss holds, release without new wait
    task automatic t_clock_loss();
        clk_ok = 1'b0;
        cyc(5);
        chk(core_rst == 1'b1, "R5 clock loss asserts", core_rst, 1);
        chk(rst_cause == 2'd0, "R5 cause clock", rst_cause, 0);
        cyc(20);
        clk_ok = 1'b1;
        cyc(8);
        chk(core_rst == 1'b0, "R5 quick release", core_rst, 0);
    endtask

    // R7: test sampled on entry, latched across release
    task automatic t_test_mode();
        test_mode = 1'b1;
        cyc(5);
        chk(oe3() == 7, "R7 no effect outside entry", oe3(), 7);
        ext_rst_n = 1'b0;
        cyc(DEB + 8);
        chk(oe3() == 0, "R7 buses off", oe3(), 0);
        test_mode = 1'b0;
        ext_rst_n = 1'b1;
        cyc(DEB + 10);
        chk(core_rst == 1'b0, "R7 released", core_rst, 0);
        chk(oe3() == 0, "R7 still latched", oe3(), 0);
        ext_rst_n = 1'b0;
        cyc(DEB + 8);
        chk(oe3() == 7, "R7 cleared on entry", oe3(), 7);
        ext_rst_n = 1'b1;
        cyc(DEB + 10);
        // power-up entry with test high
        test_mode = 1'b1;
        cyc(3);
        #1 por_i = 1'b1;
        cyc(2);
        por_i = 1'b0;
        cyc(6);
        chk(oe3() == 0, "R7 power-up capture", oe3(), 0);
        test_mode = 1'b0;
        cyc(STAB + 12);
        chk(core_rst == 1'b0, "R2 release after test por", core_rst, 0);
        chk(oe3() == 0, "R7 held after por release", oe3(), 0);
    endtask

    // R8: simultaneous supply trip and clock loss record supply
    task automatic t_priority();
        low_supply = 1'b1;
        clk_ok = 1'b0;
        cyc(5);
        chk(rst_cause == 2'd2, "R8 supply over clock", rst_cause, 2);
        chk(oe3() == 7, "R7 test low at entry", oe3(), 7);
        low_supply = 1'b0;
        clk_ok = 1'b1;
        cyc(STAB + 12);
        chk(core_rst == 1'b0, "R8 recovered", core_rst, 0);
    endtask

    initial begin
        t_power_up();
        t_pin_glitch();
        t_pin_hold();
        t_low_supply();
        t_clock_loss();
        t_test_mode();
        t_priority();
        t_async_por();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule